// File: doc/BRIEF.md
# Four-Voice Sigma-Delta Sound Generator

This block is a small register-programmed synthesiser. It has four independent voices. Each voice has a phase-accumulator oscillator with a 16-bit frequency word, a waveform choice and a 4-bit volume. The scaled samples of the four voices are added into one mix word. A first-order sigma-delta modulator turns that mix into a single-bit pulse stream. An external single-pole RC low-pass filter smooths the stream into analog audio.

A host programs the voices through a write-only byte bus made of an address, a data byte and a write strobe. Each write lands in a shadow register. A sample-rate strobe, `sample_tick`, moves every shadow value into the voices at the same moment and advances every oscillator by one step. The modulator runs on every system clock. At the default sizes the mix word is 14 bits wide.

Top module: `snd_synth`

## Requirements
- R1: A synchronous active-high `rst` clears all shadow and active settings, so frequency, waveform and volume are all 0. It also clears every phase accumulator and the modulator accumulator, and it drives `pdm_out` low. Voice v's noise register is seeded with 16'hACE1 XOR v.
- R2: `wr_addr[3:2]` selects the voice. `wr_addr[1:0]` selects the field: 0 is the frequency low byte, 1 is the frequency high byte, 2 is the waveform code in `wr_data[1:0]`, and 3 is the volume in `wr_data[3:0]`. A write changes only the field it addresses.
- R3: Bus writes have no effect on the output until the next `sample_tick`. While `sample_tick` stays low, the mix word does not change.
- R4: On each `sample_tick`, every voice adds its 16-bit frequency word to its 17-bit phase accumulator, modulo 2^17. At a 65536 Hz tick, one frequency LSB is 0.5 Hz, so the full-scale word gives about 32 kHz.
- R5: The waveform code sets the sample, taking S bits from the phase word p:
  - 0 is sawtooth: the top S bits of p.
  - 1 is square: all ones when p's MSB is 1, otherwise 0.
  - 2 is triangle: the S-1 bits just below the MSB, inverted when the MSB is 1, with a 0 appended as the LSB.
  - 3 is noise: the low S bits of the voice's noise register.
- R6: A voice's noise register shifts only on a tick whose phase addition carries out of bit 16. The shift is left by one bit, with the new bit 0 equal to the XOR of bits 15, 13, 12 and 10.
- R7: Each sample is multiplied by its volume (0 to 15). The four products are summed into a mix word of S+4+2 bits. The sum never exceeds 4·(2^S−1)·15, so it never wraps.
- R8: The modulator adds the mix word to an accumulator of the same width on every clock. `pdm_out` is the registered carry of that addition. Over any 2^(mix width) consecutive clocks with a constant mix, the count of ones on `pdm_out` equals the mix value, and a zero mix gives a constant low output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Voice (bits 3:2) and field (bits 1:0) |
| wr_data | input | 8 | Write data byte |
| sample_tick | input | 1 | One-clock strobe that applies settings and steps oscillators |
| pdm_out | output | 1 | Sigma-delta pulse stream |

## Verification
The assertions assume that `rst` is held for at least one clock, so that every register starts defined. They also assume that `sample_tick` and `wr_en` are never X outside reset, and that no other input changes the voice state. The bench meets these conditions by driving every input from a known value on the falling clock edge. It holds `sample_tick` low for the whole of each counting window, so the mix stays constant while the ones on `pdm_out` are tallied. The bench runs with an 4-bit sample width, so each counting window is 1024 clocks long. This lets it sweep every voice with every waveform, every volume, and the largest possible mix.

// File: rtl/snd_pkg.sv
package snd_pkg;

  typedef enum logic [1:0] {
    WAVE_SAW    = 2'd0,
    WAVE_SQUARE = 2'd1,
    WAVE_TRI    = 2'd2,
    WAVE_NOISE  = 2'd3
  } wave_e;

  localparam int NOISE_W = 16;
  localparam logic [NOISE_W-1:0] NOISE_SEED = 16'hACE1;

  // Fibonacci shift with feedback from bits 15, 13, 12 and 10
  function automatic logic [NOISE_W-1:0] noise_step(input logic [NOISE_W-1:0] s);
    return {s[NOISE_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/snd_regfile.sv
module snd_regfile #(
  parameter int NUM_VOICES = 4,
  parameter int DATA_W     = 8,
  parameter int VOL_W      = 4,
  localparam int VSEL_W    = $clog2(NUM_VOICES),
  localparam int ADDR_W    = VSEL_W + 2,
  localparam int FREQ_W    = 2 * DATA_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [NUM_VOICES-1:0][FREQ_W-1:0]  freq_sh,
  output logic [NUM_VOICES-1:0][1:0]         wave_sh,
  output logic [NUM_VOICES-1:0][VOL_W-1:0]   vol_sh
);

  logic [VSEL_W-1:0] vsel;
  logic [1:0]        fsel;

  assign vsel = wr_addr[ADDR_W-1:2];
  assign fsel = wr_addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_sh <= '0;
      wave_sh <= '0;
      vol_sh  <= '0;
    end else if (wr_en) begin
      case (fsel)
        2'd0:    freq_sh[vsel][DATA_W-1:0]      <= wr_data;
        2'd1:    freq_sh[vsel][FREQ_W-1:DATA_W] <= wr_data;
        2'd2:    wave_sh[vsel]                  <= wr_data[1:0];
        default: vol_sh[vsel]                   <= wr_data[VOL_W-1:0];
      endcase
    end
  end

endmodule

// File: rtl/snd_voice.sv
module snd_voice
  import snd_pkg::*;
#(
  parameter int FREQ_W = 16,
  parameter int ACC_W  = 17,
  parameter int SAMP_W = 8,
  parameter int VOL_W  = 4,
  parameter logic [NOISE_W-1:0] SEED = NOISE_SEED,
  localparam int SCALED_W = SAMP_W + VOL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [FREQ_W-1:0]   freq_in,
  input  logic [1:0]          wave_in,
  input  logic [VOL_W-1:0]    vol_in,
  output logic [VOL_W-1:0]    vol_q,
  output logic [SCALED_W-1:0] scaled
);

  logic [ACC_W-1:0]   phase;
  logic [ACC_W:0]     next_sum;
  logic [NOISE_W-1:0] noise;
  wave_e              wave_q;
  logic [SAMP_W-1:0]  samp;
  logic [SAMP_W-2:0]  tri_bits;

  assign next_sum = {1'b0, phase} + {{(ACC_W + 1 - FREQ_W){1'b0}}, freq_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      noise  <= SEED;
      wave_q <= WAVE_SAW;
      vol_q  <= '0;
    end else if (tick) begin
      phase  <= next_sum[ACC_W-1:0];
      wave_q <= wave_e'(wave_in);
      vol_q  <= vol_in;
      if (next_sum[ACC_W]) noise <= noise_step(noise);
    end
  end

  assign tri_bits = phase[ACC_W-2 -: SAMP_W-1];

  always_comb begin
    case (wave_q)
      WAVE_SAW:    samp = phase[ACC_W-1 -: SAMP_W];
      WAVE_SQUARE: samp = {SAMP_W{phase[ACC_W-1]}};
      WAVE_TRI:    samp = {(phase[ACC_W-1] ? ~tri_bits : tri_bits), 1'b0};
      default:     samp = noise[SAMP_W-1:0];
    endcase
  end

  assign scaled = SCALED_W'(samp) * SCALED_W'(vol_q);

endmodule

// File: rtl/snd_sdm.sv
module snd_sdm #(
  parameter int MIX_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MIX_W-1:0] level,
  output logic             pulse
);

  logic [MIX_W-1:0] err;
  logic [MIX_W:0]   step;

  assign step = {1'b0, err} + {1'b0, level};

  always_ff @(posedge clk) begin
    if (rst) begin
      err   <= '0;
      pulse <= 1'b0;
    end else begin
      err   <= step[MIX_W-1:0];
      pulse <= step[MIX_W];
    end
  end

endmodule

// File: rtl/snd_synth.sv
module snd_synth
  import snd_pkg::*;
#(
  parameter int NUM_VOICES = 4,
  parameter int DATA_W     = 8,
  parameter int ACC_W      = 17,
  parameter int SAMP_W     = 8,
  parameter int VOL_W      = 4,
  localparam int ADDR_W    = $clog2(NUM_VOICES) + 2,
  localparam int FREQ_W    = 2 * DATA_W,
  localparam int SCALED_W  = SAMP_W + VOL_W,
  localparam int MIX_W     = SCALED_W + $clog2(NUM_VOICES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sample_tick,
  output logic              pdm_out
);

  logic [NUM_VOICES-1:0][FREQ_W-1:0]   freq_sh;
  logic [NUM_VOICES-1:0][1:0]          wave_sh;
  logic [NUM_VOICES-1:0][VOL_W-1:0]    vol_sh;
  logic [NUM_VOICES-1:0][VOL_W-1:0]    vol_act;
  logic [NUM_VOICES-1:0][SCALED_W-1:0] scaled;
  logic [MIX_W-1:0]                    mix_sum;
  logic [MIX_W-1:0]                    mix_q;

  snd_regfile #(
    .NUM_VOICES(NUM_VOICES), .DATA_W(DATA_W), .VOL_W(VOL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq_sh(freq_sh), .wave_sh(wave_sh), .vol_sh(vol_sh)
  );

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    snd_voice #(
      .FREQ_W(FREQ_W), .ACC_W(ACC_W), .SAMP_W(SAMP_W), .VOL_W(VOL_W),
      .SEED(NOISE_SEED ^ NOISE_W'(v))
    ) u_voice (
      .clk(clk), .rst(rst), .tick(sample_tick),
      .freq_in(freq_sh[v]), .wave_in(wave_sh[v]), .vol_in(vol_sh[v]),
      .vol_q(vol_act[v]), .scaled(scaled[v])
    );
  end

  always_comb begin
    mix_sum = '0;
    for (int v = 0; v < NUM_VOICES; v++) mix_sum = mix_sum + MIX_W'(scaled[v]);
  end

  always_ff @(posedge clk) begin
    if (rst) mix_q <= '0;
    else     mix_q <= mix_sum;
  end

  snd_sdm #(.MIX_W(MIX_W)) u_sdm (
    .clk(clk), .rst(rst), .level(mix_q), .pulse(pdm_out)
  );

endmodule

// File: rtl/snd_synth_chk.sv
module snd_synth_chk #(
  parameter int NUM_VOICES = 4,
  parameter int SAMP_W     = 8,
  parameter int VOL_W      = 4,
  parameter int MIX_W      = 14
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            sample_tick,
  input logic [MIX_W-1:0]                mix,
  input logic [NUM_VOICES-1:0][VOL_W-1:0] vol_act,
  input logic                            pdm_out
);

  localparam int MIX_MAX = NUM_VOICES * ((1 << SAMP_W) - 1) * ((1 << VOL_W) - 1);

  // R3
  mix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_tick |=> ##1 $stable(mix));

  // R7
  mix_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(mix) <= MIX_MAX);

  // R7
  silent_mix_chk: assert property (@(posedge clk) disable iff (rst)
    (vol_act == '0) |=> (mix == '0));

  // R8
  zero_level_chk: assert property (@(posedge clk) disable iff (rst)
    (mix == '0) |=> !pdm_out);

  // R1
  reset_out_chk: assert property (@(posedge clk)
    rst |=> !pdm_out);

endmodule

bind snd_synth snd_synth_chk #(
  .NUM_VOICES(NUM_VOICES), .SAMP_W(SAMP_W), .VOL_W(VOL_W), .MIX_W(MIX_W)
) u_chk (
  .clk(clk), .rst(rst), .sample_tick(sample_tick),
  .mix(mix_q), .vol_act(vol_act), .pdm_out(pdm_out)
);

// File: tb/snd_synth_test.sv
module snd_synth_test;

  localparam int NV   = 4;
  localparam int SW   = 4;
  localparam int MIXW = SW + 4 + 2;
  localparam int WIN  = 1 << MIXW;
  localparam int PMOD = 1 << 17;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sample_tick = 1'b0;
  logic       pdm_out;

  always #10 clk = ~clk;

  snd_synth #(.SAMP_W(SW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_tick(sample_tick), .pdm_out(pdm_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_freq[NV], m_wave[NV], m_vol[NV];
  int a_wave[NV], a_vol[NV], m_phase[NV], m_noise[NV];

  task automatic write_reg(input int v, input int fld, input int data);
    wr_en = 1'b1; wr_addr = 4'((v << 2) | fld); wr_data = 8'(data);
    case (fld)
      0: m_freq[v] = (m_freq[v] & 32'hFF00) | (data & 255);
      1: m_freq[v] = (m_freq[v] & 32'h00FF) | ((data & 255) << 8);
      2: m_wave[v] = data & 3;
      default: m_vol[v] = data & 15;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_voice(input int v, input int f, input int w, input int vol);
    write_reg(v, 0, f & 255);
    write_reg(v, 1, (f >> 8) & 255);
    write_reg(v, 2, w);
    write_reg(v, 3, vol);
  endtask

  function automatic int noise_next(input int s);
    int fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    return ((s << 1) & 32'hFFFF) | fb;
  endfunction

  task automatic do_ticks(input int n);
    sample_tick = 1'b1;
    for (int k = 0; k < n; k++) begin
      for (int v = 0; v < NV; v++) begin
        int s = m_phase[v] + m_freq[v];
        if (s >= PMOD) m_noise[v] = noise_next(m_noise[v]);
        m_phase[v] = s % PMOD;
        a_wave[v] = m_wave[v];
        a_vol[v] = m_vol[v];
      end
    end
    repeat (n) @(negedge clk);
    sample_tick = 1'b0;
  endtask

  function automatic int sample_of(input int v);
    int msb = (m_phase[v] >> 16) & 1;
    int t = (m_phase[v] >> 13) & 7;
    case (a_wave[v])
      0: return (m_phase[v] >> 13) & 15;
      1: return msb ? 15 : 0;
      2: return (msb ? (7 - t) : t) * 2;
      default: return m_noise[v] & 15;
    endcase
  endfunction

  function automatic int exp_mix();
    int s = 0;
    for (int v = 0; v < NV; v++) s += sample_of(v) * a_vol[v];
    return s;
  endfunction

  task automatic check_mix(input string tag, input string what);
    int cnt = 0;
    int exp = exp_mix();
    repeat (2) @(negedge clk);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      cnt += int'(pdm_out);
    end
    checks++;
    if (cnt != exp) begin
      errors++;
      $display("FAIL %s %s: ones=%0d expected=%0d", tag, what, cnt, exp);
    end
  endtask

  task automatic silence_all();
    for (int v = 0; v < NV; v++) write_reg(v, 3, 0);
  endtask

  initial begin
    for (int v = 0; v < NV; v++) begin
      m_freq[v] = 0; m_wave[v] = 0; m_vol[v] = 0;
      a_wave[v] = 0; a_vol[v] = 0; m_phase[v] = 0;
      m_noise[v] = 16'hACE1 ^ v;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1, R8: cleared state gives zero mix and a low stream
    checks++;
    if (pdm_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 output after reset: got=%b expected=0", pdm_out);
    end
    check_mix("R1", "reset state");

    // R3: writes without a tick leave the output silent
    set_voice(0, 16'h9ABC, 1, 15);
    check_mix("R3", "write without tick");
    set_voice(1, 16'h4321, 0, 12);
    check_mix("R3", "second write without tick");

    // R2, R4, R5, R6: each voice alone with each waveform
    for (int w = 0; w < 4; w++) begin
      for (int v = 0; v < NV; v++) begin
        silence_all();
        set_voice(v, 16'h2345 + v * 16'h1111 + w * 16'h0777, w, 9 + v);
        do_ticks(3 + v);
        check_mix("R5", $sformatf("voice %0d wave %0d", v, w));
      end
    end

    // R7: volume sweep on a square voice held high
    silence_all();
    set_voice(2, 16'hFFFF, 1, 0);
    do_ticks(1);
    while (((m_phase[2] >> 16) & 1) == 0) do_ticks(1);
    write_reg(2, 0, 0);
    write_reg(2, 1, 0);
    for (int g = 0; g < 16; g++) begin
      write_reg(2, 3, g);
      do_ticks(1);
      check_mix("R7", $sformatf("volume %0d", g));
    end

    // R7, R8: largest possible mix, all voices square high at full volume
    for (int v = 0; v < NV; v++) begin
      silence_all();
      for (int u = 0; u < NV; u++) begin
        write_reg(u, 0, 0);
        write_reg(u, 1, 0);
      end
      write_reg(v, 0, 255);
      write_reg(v, 1, 255);
      do_ticks(1);
      while (((m_phase[v] >> 16) & 1) == 0) do_ticks(1);
      write_reg(v, 0, 0);
      write_reg(v, 1, 0);
    end
    for (int v = 0; v < NV; v++) set_voice(v, 0, 1, 15);
    do_ticks(1);
    check_mix("R7", "full scale mix 900");

    // R6: noise voice shifting on phase wraps
    silence_all();
    set_voice(3, 16'hFFFF, 3, 15);
    for (int k = 1; k <= 4; k++) begin
      do_ticks(1);
      check_mix("R6", $sformatf("noise after step %0d", k));
    end
    write_reg(3, 0, 0);
    write_reg(3, 1, 0);
    do_ticks(3);
    check_mix("R6", "noise frozen at zero frequency");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule